// File: doc/BRIEF.md
# Mains Time-of-Day Prescaler

This block turns a slow, asynchronous square wave taken from the mains supply into a 10 Hz count enable for a BCD time-of-day counter. A one-hot ring of four flops divides the bus clock by four. It produces a phase enable, and the edge logic and the step output advance only on that enable. Each rising edge on the input pin is synchronized and held pending until the next phase. Recognizing the edge clears the pending flag and advances a small predivider.

The predivider counts recognized edges modulo 5 when `fast_sel_i` is 1 (50 Hz supply) and modulo 6 when it is 0 (60 Hz supply). At each wrap it emits a one-cycle overflow pulse. A downstream counter then receives exactly one step enable, aligned to the phase enable. While `hold_i` is high the predivider stays cleared. Software uses this to restart the 10 Hz phase after it writes the time.

Top module: `tod_prescaler`

## Requirements
- R1: `phase_o` is high in exactly one of every four clock cycles. It is high while reset is held and again on every fourth rising clock edge after release.
- R2: Each rising edge of `mains_i` advances the predivider by exactly one. This holds when the high and the low phases of `mains_i` each last at least 8 clock cycles. A recognized edge is acknowledged, so it is never counted twice.
- R3: If `mains_i` is high when reset is released, that level counts as one edge after release.
- R4: With `fast_sel_i` = 1, `ovf_o` pulses once for every 5 counted edges after a clear.
- R5: With `fast_sel_i` = 0, `ovf_o` pulses once for every 6 counted edges after a clear.
- R6: `fast_sel_i` is taken only while the predivider is at its clear state. A change made after counting has started applies from the next clear.
- R7: While `hold_i` is 1 the predivider is held cleared and `ovf_o` stays low. Edges seen during hold are not counted.
- R8: `ovf_o` is a single-cycle pulse.
- R9: Each `ovf_o` pulse is followed by exactly one single-cycle `step_o`. It arrives within 4 cycles and always in a cycle where `phase_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mains_i | input | 1 | Asynchronous mains-derived square wave |
| fast_sel_i | input | 1 | 1: divide by 5, 0: divide by 6 |
| hold_i | input | 1 | Holds the predivider cleared |
| phase_o | output | 1 | Divide-by-four phase enable |
| ovf_o | output | 1 | Predivider overflow pulse |
| step_o | output | 1 | One-step enable for the BCD counter |

## Verification
A wrong count state shows at the ports as an overflow that comes one edge early or one edge late. It appears within at most six input edges of a clear, so sweeping every edge count from 0 to 13 in both modes exposes it. A stuck pending flag shows as extra overflows, because edges are counted twice. A lost acknowledge shows the same way. A broken step path shows within four cycles of an overflow, either as a missing step or as a step off the phase enable.

// File: rtl/tod_prescaler_pkg.sv
package tod_prescaler_pkg;
  typedef enum logic {
    RATIO_SLOW = 1'b0,
    RATIO_FAST = 1'b1
  } ratio_sel_e;

  function automatic int unsigned pick_ratio(input logic sel, input int unsigned fast,
                                             input int unsigned slow);
    return sel ? fast : slow;
  endfunction

  function automatic int unsigned max_ratio(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tod_phase_ring.sv
module tod_phase_ring #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ena_o
);
  logic [LEN-1:0] ring_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= LEN'(1);
    else         ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
  end

  assign ena_o = ring_q[0];

  AST_RING_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(ring_q)); // R1
endmodule

// File: rtl/tod_edge_capture.sv
module tod_edge_capture #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic ena_i,
  output logic det_o
);
  // top bit is the history flop for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 pend_q;
  logic                 rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise  = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign det_o = pend_q & ena_i;

  // a new edge wins over the acknowledge of the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= rise | (pend_q & ~det_o);
  end

  AST_PEND_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o && !rise) |=> !pend_q); // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ena_i) |=> pend_q); // R2
endmodule

// File: rtl/tod_predivider.sv
module tod_predivider #(
  parameter int unsigned DIV_FAST = 5,
  parameter int unsigned DIV_SLOW = 6,
  parameter int unsigned CNT_W    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic sel_fast_i,
  input  logic hold_i,
  output logic ovf_o
);
  import tod_prescaler_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             sel_q;
  logic             ovf_q;

  assign last = sel_q ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= RATIO_SLOW;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (hold_i) begin
        cnt_q <= '0;
      end else if (det_i) begin
        if (cnt_q == last) begin
          cnt_q <= '0;
          ovf_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // mode follows the pin only while the count rests at zero
      if (cnt_q == '0) sel_q <= sel_fast_i;
    end
  end

  assign ovf_o = ovf_q;

  AST_HOLD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0 && !ovf_q)); // R7
  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last); // R4
  AST_CNT_ON_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ($past(det_i) || $past(hold_i))); // R2
  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) != '0) |-> $stable(sel_q)); // R6
  AST_OVF_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> !ovf_q); // R8
endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int unsigned RING_LEN    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_FAST    = 5,
  parameter int unsigned DIV_SLOW    = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mains_i,
  input  logic fast_sel_i,
  input  logic hold_i,
  output logic phase_o,
  output logic ovf_o,
  output logic step_o
);
  import tod_prescaler_pkg::*;

  localparam int unsigned CNT_W = $clog2(max_ratio(DIV_FAST, DIV_SLOW));

  logic ena;
  logic det;
  logic ovf;
  logic ovf_d_q;
  logic step_pend_q;

  tod_phase_ring #(.LEN(RING_LEN)) i_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ena_o (ena)
  );

  tod_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (mains_i),
    .ena_i (ena),
    .det_o (det)
  );

  tod_predivider #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW),
    .CNT_W   (CNT_W)
  ) i_prediv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_i     (det),
    .sel_fast_i(fast_sel_i),
    .hold_i    (hold_i),
    .ovf_o     (ovf)
  );

  // one count step per overflow rise, issued on the next phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_d_q     <= 1'b0;
      step_pend_q <= 1'b0;
    end else begin
      ovf_d_q     <= ovf;
      step_pend_q <= (ovf & ~ovf_d_q) | (step_pend_q & ~ena);
    end
  end

  assign step_o  = step_pend_q & ena;
  assign phase_o = ena;
  assign ovf_o   = ovf;

  AST_STEP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o); // R9
  AST_STEP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> step_pend_q); // R9
endmodule

// File: tb/test_tod_prescaler.sv
module test_tod_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mains = 1'b0;
  logic fast_sel = 1'b0;
  logic hold = 1'b0;
  logic phase, ovf, step;

  int n_chk = 0, n_bad = 0;
  int ovf_seen = 0, step_seen = 0, bad_phase = 0, bad_lat = 0;
  int since_ovf = 100, since_phase = 0, bad_spacing = 0, cycles = 0;

  tod_prescaler i_tod_prescaler (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .mains_i   (mains),
    .fast_sel_i(fast_sel),
    .hold_i    (hold),
    .phase_o   (phase),
    .ovf_o     (ovf),
    .step_o    (step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      if (ovf) begin ovf_seen++; since_ovf = 0; end
      else since_ovf++;
      if (step) begin
        step_seen++;
        if (!phase) bad_phase++;
        if (since_ovf > 4) bad_lat++;
      end
      if (phase) begin
        if (since_phase != 4) bad_spacing++;
        since_phase = 1;
      end else since_phase++;
    end
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_edge();
    mains = 1'b1; wait_cyc(8);
    mains = 1'b0; wait_cyc(8);
  endtask

  task automatic clear_div();
    hold = 1'b1; wait_cyc(6);
    hold = 1'b0; wait_cyc(2);
  endtask

  initial begin
    int base;
    wait_cyc(3);
    check(phase == 1'b1, "R1 phase in reset", phase, 1);
    check(ovf == 1'b0, "R8 ovf in reset", ovf, 0);
    check(step == 1'b0, "R9 step in reset", step, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    since_phase = 4;
    wait_cyc(40);
    check(bad_spacing == 0, "R1 phase spacing", bad_spacing, 0);

    // R4/R5 sweep over edge counts in both modes
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 14; n++) begin
        int exp_ovf;
        fast_sel = m[0];
        clear_div();
        base = ovf_seen;
        for (int e = 0; e < n; e++) do_edge();
        wait_cyc(8);
        exp_ovf = n / (m ? 5 : 6);
        check(ovf_seen - base == exp_ovf, m ? "R4 divide by five" : "R5 divide by six",
              ovf_seen - base, exp_ovf);
      end
    end
    check(step_seen == ovf_seen, "R9 step count", step_seen, ovf_seen);
    check(bad_phase == 0, "R9 step on phase", bad_phase, 0);
    check(bad_lat == 0, "R9 step latency", bad_lat, 0);

    // R7: hold suppresses counting
    fast_sel = 1'b1;
    hold = 1'b1;
    base = ovf_seen;
    for (int e = 0; e < 12; e++) do_edge();
    check(ovf_seen == base, "R7 no ovf under hold", ovf_seen - base, 0);
    hold = 1'b0; wait_cyc(2);
    for (int e = 0; e < 4; e++) do_edge();
    check(ovf_seen == base, "R7 edges under hold not counted", ovf_seen - base, 0);
    do_edge(); wait_cyc(8);
    check(ovf_seen - base == 1, "R7 count resumes", ovf_seen - base, 1);

    // R6: mode change mid-count is deferred
    fast_sel = 1'b0;
    clear_div();
    base = ovf_seen;
    do_edge(); do_edge();
    fast_sel = 1'b1;
    for (int e = 0; e < 3; e++) do_edge();
    wait_cyc(8);
    check(ovf_seen == base, "R6 no early wrap", ovf_seen - base, 0);
    do_edge(); wait_cyc(8);
    check(ovf_seen - base == 1, "R6 wrap at six", ovf_seen - base, 1);
    for (int e = 0; e < 5; e++) do_edge();
    wait_cyc(8);
    check(ovf_seen - base == 2, "R6 new ratio after clear", ovf_seen - base, 2);

    // R2: wide pulse counted once
    fast_sel = 1'b1;
    clear_div();
    base = ovf_seen;
    for (int e = 0; e < 4; e++) begin
      mains = 1'b1; wait_cyc(40);
      mains = 1'b0; wait_cyc(8);
    end
    check(ovf_seen == base, "R2 long high counted once", ovf_seen - base, 0);
    do_edge(); wait_cyc(8);
    check(ovf_seen - base == 1, "R2 fifth edge wraps", ovf_seen - base, 1);

    // R3: input high across reset release counts once
    fast_sel = 1'b1;
    rst_ni = 1'b0;
    mains = 1'b1;
    wait_cyc(5);
    @(posedge clk); #1 rst_ni = 1'b1;
    since_phase = 4;
    base = ovf_seen;
    wait_cyc(10);
    mains = 1'b0; wait_cyc(8);
    for (int e = 0; e < 3; e++) do_edge();
    wait_cyc(8);
    check(ovf_seen == base, "R3 four edges no wrap", ovf_seen - base, 0);
    do_edge(); wait_cyc(8);
    check(ovf_seen - base == 1, "R3 release level counted", ovf_seen - base, 1);

    check(step_seen == ovf_seen, "R9 final step count", step_seen, ovf_seen);
    check(bad_phase == 0 && bad_lat == 0, "R9 final step timing", bad_phase + bad_lat, 0);
    check(bad_spacing == 0, "R1 final phase spacing", bad_spacing, 0);
    finish_run();
  end
endmodule